// File: doc/BRIEF.md
# Reference Pulse Qualifier

This block watches a reference strobe that is expected to arrive once every nominal period, with a small allowed drift. It also expects each strobe to be high for exactly one clock cycle. It measures the number of clock cycles from each rising edge to the next. It then decides whether the reference can be trusted and shows that decision on a single `ref_ok` flag. Logic downstream of this block, such as a frequency tracker, uses the reference only while the flag is high.

The flag is conservative. After reset, or after any fault, the first rising edge only starts the interval timer. The flag rises only when a later edge closes an interval that lies inside the tolerance window. Any of three faults clears the flag at the next clock edge:

- an interval outside the window;
- a strobe held high for two or more cycles;
- a strobe that fails to arrive before the window closes.

Each time a pulse is accepted, the block emits a one-cycle strobe. It also holds the most recently measured interval on an output, so the reference rate can be observed. The nominal period `PERIOD_CYC` and the half-width of the window `SLACK_CYC` are parameters counted in clock cycles. The window runs from `PERIOD_CYC-SLACK_CYC` to `PERIOD_CYC+SLACK_CYC`, both ends included.

Top module: `ref_pulse_qual`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it, `ref_ok`, `accept_stb` and `interval_q` are all 0.
- R2: A rising edge seen while no interval is being timed starts timing only. It raises neither `accept_stb` nor `ref_ok`, and it leaves `interval_q` unchanged.
- R3: When a rising edge closes a timed interval, `interval_q` takes the number of clock cycles since the previous timed rising edge. The new value is visible one cycle after the edge is sampled.
- R4: An interval from `PERIOD_CYC-SLACK_CYC` to `PERIOD_CYC+SLACK_CYC` inclusive is accepted. One cycle after the edge is sampled, `accept_stb` is 1 for that cycle and `ref_ok` is 1.
- R5: An interval outside the window drives `ref_ok` to 0 one cycle after the edge and does not raise `accept_stb`. That rejected edge starts a new timed interval, so the next edge can be accepted.
- R6: If `PERIOD_CYC+SLACK_CYC+1` cycles pass after a timed edge with no new rising edge, `ref_ok` goes to 0 and timing stops. `ref_ok` is still 1 exactly `PERIOD_CYC+SLACK_CYC` cycles after the edge.
- R7: If the pulse input is sampled high on two consecutive cycles, `ref_ok` is 0 from the next cycle on and timing stops. The next rising edge then only starts timing.
- R8: Once `ref_ok` is 0, it rises again only together with an `accept_stb`. After a timeout or a wide pulse, that takes two correctly spaced single-cycle pulses.
- R9: `accept_stb` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Reference strobe, already synchronous to `clk` |
| ref_ok | output | 1 | Reference is currently trusted |
| accept_stb | output | 1 | One-cycle strobe for each accepted pulse |
| interval_q | output | $clog2(PERIOD_CYC+SLACK_CYC+2) | Last measured edge-to-edge interval in cycles |

## Verification
The following hold on every cycle, for any stimulus:

- `accept_stb` is never high twice in a row.
- `ref_ok` only rises together with a strobe.
- A double-high sample or an expired timer forces the flag low one edge later.
- An arming edge never strobes.
- The running counter never passes one beyond the window limit.

The bench's scenarios cover what those properties cannot: that the two window boundaries are accepted and the cycle just outside is rejected, that a rejected edge restarts timing, the exact cycle on which a timeout clears the flag, and that two good pulses are needed after a timeout or a wide pulse.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

    // Edge classification of the sampled strobe
    typedef struct packed {
        logic rise;   // low last cycle, high now
        logic wide;   // high last cycle and high now
    } strobe_ev_t;

    // Outcome of one cycle of judgement
    typedef enum logic [2:0] {
        JD_IDLE,    // nothing happens
        JD_ARM,     // first edge: start timing
        JD_PASS,    // interval in window: accept
        JD_REJECT,  // interval outside window: fail, restart timing
        JD_DROP     // wide pulse or timeout: fail, stop timing
    } judge_e;

    function automatic judge_e judge(input logic armed, input strobe_ev_t ev,
                                     input logic in_win, input logic expired);
        if (ev.wide)       return JD_DROP;
        if (ev.rise) begin
            if (!armed)    return JD_ARM;
            if (in_win)    return JD_PASS;
            return JD_REJECT;
        end
        if (expired)       return JD_DROP;
        return JD_IDLE;
    endfunction

    function automatic logic restarts(input judge_e j);
        return (j == JD_ARM) || (j == JD_PASS) || (j == JD_REJECT);
    endfunction

endpackage

// File: rtl/rpq_edge_det.sv
module rpq_edge_det
    import rpq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_i,
    output strobe_ev_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= strobe_i;
    end

    always_comb begin
        ev_o.rise = strobe_i & ~prev_q;
        ev_o.wide = strobe_i &  prev_q;
    end
endmodule

// File: rtl/rpq_interval_ctr.sv
module rpq_interval_ctr #(
    parameter int unsigned CW     = 8,
    parameter int unsigned HI_CYC = 204
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    input  logic          stop_i,
    output logic [CW-1:0] cnt_o,
    output logic          armed_o,
    output logic          expired_o
);
    localparam logic [CW-1:0] HI_V  = CW'(HI_CYC);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o   <= '0;
            armed_o <= 1'b0;
        end else if (restart_i) begin
            cnt_o   <= ONE_V;
            armed_o <= 1'b1;
        end else if (stop_i) begin
            armed_o <= 1'b0;
        end else if (armed_o && cnt_o <= HI_V) begin
            cnt_o   <= cnt_o + ONE_V;
        end
    end

    assign expired_o = armed_o && (cnt_o > HI_V);

    // R6: while timing, the count never runs past one beyond the window
    a_r6_cnt_capped: assert property (@(posedge clk) disable iff (rst)
        armed_o |-> (cnt_o <= HI_V + ONE_V));

    // R6: an expiry stops timing unless an edge restarts it
    a_r6_expiry_disarms: assert property (@(posedge clk) disable iff (rst)
        (expired_o && !restart_i) |=> !armed_o);
endmodule

// File: rtl/rpq_status.sv
module rpq_status
    import rpq_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  judge_e        verdict_i,
    input  logic [CW-1:0] cnt_i,
    output logic          ok_o,
    output logic          stb_o,
    output logic [CW-1:0] interval_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ok_o       <= 1'b0;
            stb_o      <= 1'b0;
            interval_o <= '0;
        end else begin
            unique case (verdict_i)
                JD_PASS: begin
                    ok_o       <= 1'b1;
                    stb_o      <= 1'b1;
                    interval_o <= cnt_i;
                end
                JD_REJECT: begin
                    ok_o       <= 1'b0;
                    stb_o      <= 1'b0;
                    interval_o <= cnt_i;
                end
                JD_DROP: begin
                    ok_o  <= 1'b0;
                    stb_o <= 1'b0;
                end
                default: stb_o <= 1'b0;
            endcase
        end
    end

    // R9: strobe lasts a single cycle
    a_r9_stb_single: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);

    // R8: the flag only comes back together with an accepted pulse
    a_r8_ok_rise_with_stb: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_o) |-> stb_o);
endmodule

// File: rtl/ref_pulse_qual.sv
module ref_pulse_qual
    import rpq_pkg::*;
#(
    parameter int unsigned PERIOD_CYC = 200,
    parameter int unsigned SLACK_CYC  = 4,
    localparam int unsigned HI_CYC    = PERIOD_CYC + SLACK_CYC,
    localparam int unsigned LO_CYC    = PERIOD_CYC - SLACK_CYC,
    localparam int unsigned CW        = $clog2(HI_CYC + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_in,
    output logic          ref_ok,
    output logic          accept_stb,
    output logic [CW-1:0] interval_q
);
    localparam logic [CW-1:0] LO_V = CW'(LO_CYC);
    localparam logic [CW-1:0] HI_V = CW'(HI_CYC);

    strobe_ev_t    ev;
    logic [CW-1:0] cnt;
    logic          armed;
    logic          expired;
    logic          in_win;
    judge_e        verdict;

    rpq_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (pulse_in),
        .ev_o     (ev)
    );

    assign in_win  = (cnt >= LO_V) && (cnt <= HI_V);
    assign verdict = judge(armed, ev, in_win, expired);

    rpq_interval_ctr #(.CW(CW), .HI_CYC(HI_CYC)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restarts(verdict)),
        .stop_i    (verdict == JD_DROP),
        .cnt_o     (cnt),
        .armed_o   (armed),
        .expired_o (expired)
    );

    rpq_status #(.CW(CW)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .verdict_i  (verdict),
        .cnt_i      (cnt),
        .ok_o       (ref_ok),
        .stb_o      (accept_stb),
        .interval_o (interval_q)
    );

    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!ref_ok && !accept_stb && interval_q == '0));

    // R7: a double-high sample clears the flag at the next edge
    a_r7_wide_drops: assert property (@(posedge clk) disable iff (rst)
        ev.wide |=> !ref_ok);

    // R6: an expired timer clears the flag at the next edge
    a_r6_timeout_drops: assert property (@(posedge clk) disable iff (rst)
        expired |=> !ref_ok);

    // R2: an arming edge never strobes
    a_r2_arm_no_stb: assert property (@(posedge clk) disable iff (rst)
        (ev.rise && !armed) |=> !accept_stb);

    // R4: an accepted interval lies in the window and sets the flag
    a_r4_stb_in_window: assert property (@(posedge clk) disable iff (rst)
        accept_stb |-> (ref_ok && interval_q >= LO_V && interval_q <= HI_V));
endmodule

// File: tb/ref_pulse_qual_tb.sv
module ref_pulse_qual_tb;
    localparam int NOM = 200;
    localparam int TOL = 4;
    localparam int HI  = NOM + TOL;
    localparam int LO  = NOM - TOL;
    localparam int CW  = $clog2(HI + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pulse_in = 1'b0;
    logic          ref_ok;
    logic          accept_stb;
    logic [CW-1:0] interval_q;

    int total = 0;
    int bad   = 0;
    int since = 0;

    always #5 clk = ~clk;

    ref_pulse_qual #(.PERIOD_CYC(NOM), .SLACK_CYC(TOL)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pulse_in   (pulse_in),
        .ref_ok     (ref_ok),
        .accept_stb (accept_stb),
        .interval_q (interval_q)
    );

    // Behavioural reference: time stamps instead of counters
    longint cyc = 0;
    longint t_last = 0;
    bit     m_armed = 0, m_prev = 0, m_ok = 0, m_stb = 0;
    int     m_iv = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_armed = 0; m_prev = 0; m_ok = 0; m_stb = 0; m_iv = 0;
        end else begin
            if (pulse_in && m_prev) begin
                m_ok = 0; m_stb = 0; m_armed = 0;
            end else if (pulse_in && !m_prev) begin
                if (m_armed) begin
                    m_iv  = int'(cyc - t_last);
                    m_stb = (m_iv >= LO && m_iv <= HI);
                    m_ok  = m_stb;
                end else begin
                    m_stb = 0;
                end
                m_armed = 1;
                t_last  = cyc;
            end else begin
                m_stb = 0;
                if (m_armed && (cyc - t_last) > HI) begin
                    m_ok = 0; m_armed = 0;
                end
            end
            m_prev = pulse_in;
        end
    end

    always @(negedge clk) begin
        if (cyc > 0) begin
            total++;
            if (ref_ok !== m_ok || accept_stb !== m_stb || int'(interval_q) !== m_iv) begin
                bad++;
                if (ref_ok !== m_ok)
                    $display("FAIL R8 cyc=%0d ref_ok act=%0d exp=%0d", cyc, ref_ok, m_ok);
                if (accept_stb !== m_stb)
                    $display("FAIL R4 cyc=%0d accept_stb act=%0d exp=%0d", cyc, accept_stb, m_stb);
                if (int'(interval_q) !== m_iv)
                    $display("FAIL R3 cyc=%0d interval_q act=%0d exp=%0d", cyc, interval_q, m_iv);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        since++;
    endtask

    // Raise the strobe so its rise lands iv cycles after the previous one
    task automatic send(input int iv, input int w);
        while (since < iv - 1) tick();
        pulse_in = 1'b1;
        @(negedge clk);
        since = 0;
        for (int k = 1; k < w; k++) tick();
        pulse_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ok in reset", int'(ref_ok), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ok", int'(ref_ok), 0);
        chk("R1 stb", int'(accept_stb), 0);
        chk("R1 interval", int'(interval_q), 0);

        send(1, 1);
        chk("R2 first edge stb", int'(accept_stb), 0);
        chk("R2 first edge ok", int'(ref_ok), 0);
        chk("R2 first edge interval", int'(interval_q), 0);

        send(NOM, 1);
        chk("R4 nominal stb", int'(accept_stb), 1);
        chk("R4 nominal ok", int'(ref_ok), 1);
        chk("R3 nominal interval", int'(interval_q), NOM);
        tick();
        chk("R9 stb single", int'(accept_stb), 0);
        chk("R4 ok held", int'(ref_ok), 1);

        send(LO, 1);
        chk("R4 low edge stb", int'(accept_stb), 1);
        chk("R3 low edge interval", int'(interval_q), LO);
        send(HI, 1);
        chk("R4 high edge stb", int'(accept_stb), 1);
        chk("R3 high edge interval", int'(interval_q), HI);

        send(LO - 1, 1);
        chk("R5 early ok", int'(ref_ok), 0);
        chk("R5 early stb", int'(accept_stb), 0);
        chk("R3 early interval", int'(interval_q), LO - 1);
        send(NOM, 1);
        chk("R5 restart stb", int'(accept_stb), 1);
        chk("R5 restart ok", int'(ref_ok), 1);

        while (since < HI) tick();
        chk("R6 ok at limit", int'(ref_ok), 1);
        tick();
        chk("R6 ok after limit", int'(ref_ok), 0);

        send(1, 1);
        chk("R8 arm after timeout ok", int'(ref_ok), 0);
        chk("R8 arm after timeout stb", int'(accept_stb), 0);
        send(NOM, 1);
        chk("R8 rearm stb", int'(accept_stb), 1);
        chk("R8 rearm ok", int'(ref_ok), 1);

        send(NOM, 2);
        chk("R7 wide ok", int'(ref_ok), 0);
        chk("R7 wide stb", int'(accept_stb), 0);
        send(NOM, 1);
        chk("R7 disarmed stb", int'(accept_stb), 0);
        chk("R7 disarmed ok", int'(ref_ok), 0);
        send(NOM, 1);
        chk("R8 after wide stb", int'(accept_stb), 1);

        send(NOM, 3);
        chk("R7 triple ok", int'(ref_ok), 0);
        repeat (2 * NOM) tick();
        chk("R6 idle ok", int'(ref_ok), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule